// File: doc/BRIEF.md
# Signaling Octet Double-Match Receive Filter

This block receives one serial signaling octet per frame, most significant bit first. A frame-sync strobe marks the first bit of each octet. The block splits the octet into three parts: a command field and two raw handshake flags. The command field holds five output-latch data bits and one channel-select bit. There are two channels. Each channel has its own stored command register, and that register drives the channel's group of programmable output pins.

A new command value is accepted only after it arrives unchanged in two consecutive frames. On its first appearance, a field that differs from the addressed channel's register is parked in a holding register and a pending flag is set. When the next frame brings the same field, the value is written into the addressed channel's register. A field that matches the current register, or one that replaces the parked value, follows the rules listed below. An accepted value reaches the pins one frame after acceptance. Each pin passes its value only where the direction input marks it as an output.

Top module: `ci_rx_filter`

## Requirements
- R1: On each clock the block samples `sdata`. A high `frame_sync` marks the sample as octet bit 7. The seven samples that follow are bits 6 down to 0. `octet_valid` pulses high for exactly one cycle, in the cycle after bit 0 is sampled. Samples taken without a preceding `frame_sync` produce no pulse.
- R2: Octet bit 1 appears on `mr` and bit 0 appears on `mx`. Both are updated with each `octet_valid` pulse and hold their value until the next octet.
- R3: The command field is octet bits 7..3 (data, bit 7 being pin 4) plus bit 2 (channel select: 0 selects channel 0, 1 selects channel 1). A field that differs from the selected channel's register is parked, the pending flag is set, and no channel register changes.
- R4: While pending, a field equal to the parked one and different from the selected channel's register is written into that register, and pending is cleared.
- R5: While pending, a field that differs from both the parked field and the selected channel's register replaces the parked field, pending stays set, and no register changes. Acceptance then needs that new field in the following frame.
- R6: A field equal to the selected channel's register leaves all registers unchanged and clears pending. A field parked earlier is then no longer accepted on its next appearance.
- R7: A value accepted in frame N appears on the channel's pins after the octet of frame N+1 completes. Pins change only in the cycle after an `octet_valid` pulse.
- R8: Pin bit k of channel c equals the channel's stored bit AND `pin_dir` bit k of channel c. The direction input acts combinationally.
- R9: Reset clears both channel registers, the parked field, the pending flag, the pins, `mr`, `mx` and `octet_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | High during the octet's bit 7 sample |
| sdata | input | 1 | Serial signaling data, MSB first |
| pin_dir | input | 10 | Per-pin output enable; bits 4:0 channel 0, bits 9:5 channel 1 |
| pin_out | output | 10 | Programmable output pins; bits 4:0 channel 0, bits 9:5 channel 1 |
| mr | output | 1 | Raw handshake bit from octet bit 1 |
| mx | output | 1 | Raw handshake bit from octet bit 0 |
| octet_valid | output | 1 | One-cycle pulse per completed octet |

## Verification
A wrong pending flag or a wrong parked field cannot be seen in the frame where it occurs. It shows up two frames later, when a pin group either updates or fails to update. The bench therefore checks the pins after every frame of a sequence that walks through staging, replacement, clearing by a matching field and channel switching. A bad channel register shows up on the pins one frame later. A bad octet capture shows up on `mr` and `mx` in the same frame.

// File: rtl/ci_rx_pkg.sv
package ci_rx_pkg;
    typedef enum logic [1:0] {
        RULE_NONE,
        RULE_HOLD,
        RULE_STAGE,
        RULE_ACCEPT
    } rule_e;
endpackage

// File: rtl/ci_rx_deser.sv
module ci_rx_deser #(
    parameter int OCT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic             sdata,
    output logic [OCT_W-1:0] octet,
    output logic             octet_vld
);
    localparam int CNT_W = $clog2(OCT_W + 1);

    typedef struct packed {
        logic [OCT_W-2:0] sh;
        logic [CNT_W-1:0] cnt;
        logic [OCT_W-1:0] oct;
        logic             vld;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (frame_sync) begin
            st_d.sh  = {{(OCT_W-2){1'b0}}, sdata};
            st_d.cnt = CNT_W'(1);
        end else if (st_q.cnt != '0 && st_q.cnt < CNT_W'(OCT_W)) begin
            st_d.sh  = {st_q.sh[OCT_W-3:0], sdata};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(OCT_W - 1)) begin
                st_d.oct = {st_q.sh, sdata};
                st_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign octet     = st_q.oct;
    assign octet_vld = st_q.vld;

    // R1: the completion strobe lasts a single cycle
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        octet_vld |=> !octet_vld);

    // R2: captured octet moves only together with the strobe
    a_r2_octet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !octet_vld |-> $stable(octet));
endmodule

// File: rtl/ci_rx_filter_core.sv
module ci_rx_filter_core
    import ci_rx_pkg::*;
#(
    parameter int DATA_W = 5,
    parameter int ADDR_W = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             vld,
    input  logic [DATA_W+ADDR_W-1:0]         field,
    output logic [(1<<ADDR_W)*DATA_W-1:0]    ci_flat
);
    localparam int FW  = DATA_W + ADDR_W;
    localparam int NCH = 1 << ADDR_W;

    typedef struct packed {
        logic [NCH-1:0][DATA_W-1:0] ci;
        logic [FW-1:0]              sec;
        logic                       lat;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [FW-1:0]     cur;
    rule_e             rule;

    assign addr = field[ADDR_W-1:0];
    assign data = field[FW-1:ADDR_W];
    assign cur  = {st_q.ci[addr], addr};

    always_comb begin
        if (!vld)                                 rule = RULE_NONE;
        else if (field == cur)                    rule = RULE_HOLD;
        else if (st_q.lat && field == st_q.sec)   rule = RULE_ACCEPT;
        else                                      rule = RULE_STAGE;
    end

    always_comb begin
        st_d = st_q;
        case (rule)
            RULE_HOLD: begin
                st_d.lat = 1'b0;
            end
            RULE_ACCEPT: begin
                st_d.ci[addr] = data;
                st_d.lat      = 1'b0;
            end
            RULE_STAGE: begin
                st_d.sec = field;
                st_d.lat = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ci_flat = st_q.ci;

    // R3: a new differing field is parked and pending is raised
    a_r3_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && field != cur && !(st_q.lat && field == st_q.sec))
        |=> (st_q.lat && st_q.sec == $past(field) && $stable(st_q.ci)));

    // R4: second identical field lands in the addressed register
    a_r4_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && field != cur && st_q.lat && field == st_q.sec)
        |=> (!st_q.lat && st_q.ci[$past(addr)] == $past(data)));

    // R6: a field equal to the register clears pending and changes nothing
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && field == cur) |=> (!st_q.lat && $stable(st_q.ci)));

    // R7: registers move only on a completed octet
    a_r7_ci_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vld) |-> $stable(st_q.ci));
endmodule

// File: rtl/ci_rx_pins.sv
module ci_rx_pins #(
    parameter int DATA_W = 5,
    parameter int NCH    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vld,
    input  logic [NCH*DATA_W-1:0] ci_flat,
    input  logic [NCH*DATA_W-1:0] dir_flat,
    output logic [NCH*DATA_W-1:0] pins_flat
);
    logic [NCH*DATA_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (vld) hold_d = ci_flat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign pins_flat[g*DATA_W +: DATA_W] =
            hold_q[g*DATA_W +: DATA_W] & dir_flat[g*DATA_W +: DATA_W];
    end

    // R7: the pin stage is frozen between octet strobes
    a_r7_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vld) |-> $stable(hold_q));
endmodule

// File: rtl/ci_rx_filter.sv
module ci_rx_filter #(
    parameter int DATA_W = 5,
    parameter int ADDR_W = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                frame_sync,
    input  logic                                sdata,
    input  logic [(1<<ADDR_W)*DATA_W-1:0]       pin_dir,
    output logic [(1<<ADDR_W)*DATA_W-1:0]       pin_out,
    output logic                                mr,
    output logic                                mx,
    output logic                                octet_valid
);
    localparam int FW    = DATA_W + ADDR_W;
    localparam int OCT_W = FW + 2;
    localparam int NCH   = 1 << ADDR_W;

    logic [OCT_W-1:0]      octet;
    logic                  vld;
    logic [NCH*DATA_W-1:0] ci_flat;

    ci_rx_deser #(.OCT_W(OCT_W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .sdata      (sdata),
        .octet      (octet),
        .octet_vld  (vld)
    );

    ci_rx_filter_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (vld),
        .field   (octet[OCT_W-1:2]),
        .ci_flat (ci_flat)
    );

    ci_rx_pins #(.DATA_W(DATA_W), .NCH(NCH)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld       (vld),
        .ci_flat   (ci_flat),
        .dir_flat  (pin_dir),
        .pins_flat (pin_out)
    );

    assign mr          = octet[1];
    assign mx          = octet[0];
    assign octet_valid = vld;
endmodule

// File: tb/ci_rx_filter_test.sv
module ci_rx_filter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       sdata = 1'b0;
    logic [9:0] pin_dir = 10'h3FF;
    logic [9:0] pin_out;
    logic       mr, mx, octet_valid;

    int checks = 0;
    int fails  = 0;
    int vcnt   = 0;
    logic vld_slot;

    always #4 clk = ~clk;

    ci_rx_filter uut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .sdata(sdata),
        .pin_dir(pin_dir), .pin_out(pin_out), .mr(mr), .mx(mx),
        .octet_valid(octet_valid)
    );

    always @(negedge clk) if (octet_valid) vcnt++;

    // octet, expected ch0 pins, expected ch1 pins after that frame (dir all ones)
    localparam logic [17:0] VEC [0:16] = '{
        {8'hA8, 5'h00, 5'h00}, {8'hA8, 5'h00, 5'h00}, {8'hA8, 5'h15, 5'h00},
        {8'h56, 5'h15, 5'h00}, {8'hFD, 5'h15, 5'h00}, {8'hFD, 5'h15, 5'h00},
        {8'h18, 5'h15, 5'h1F}, {8'hA8, 5'h15, 5'h1F}, {8'h18, 5'h15, 5'h1F},
        {8'h18, 5'h15, 5'h1F}, {8'h04, 5'h03, 5'h1F}, {8'h03, 5'h03, 5'h1F},
        {8'h07, 5'h03, 5'h1F}, {8'h04, 5'h03, 5'h1F}, {8'h00, 5'h03, 5'h00},
        {8'h00, 5'h03, 5'h00}, {8'h00, 5'h00, 5'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] o, input logic with_sync);
        vcnt = 0;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            frame_sync = with_sync && (i == 7);
            sdata      = o[i];
        end
        @(negedge clk);
        frame_sync = 1'b0;
        sdata      = 1'b0;
        vld_slot   = octet_valid;
        repeat (7) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 pins after reset", pin_out, 0);
        chk("R9 mr/mx after reset", {mr, mx}, 0);
        chk("R9 octet_valid after reset", octet_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 bits with no frame_sync give no octet
        send(8'hFF, 1'b0);
        chk("R1 no strobe without frame_sync", vcnt, 0);
        chk("R2 mr/mx unchanged without frame_sync", {mr, mx}, 0);

        for (int r = 0; r < 17; r++) begin
            send(VEC[r][17:10], 1'b1);
            chk($sformatf("R1 strobe slot row %0d", r), vld_slot, 1);
            chk($sformatf("R1 one strobe row %0d", r), vcnt, 1);
            chk($sformatf("R2 mr row %0d", r), mr, VEC[r][11]);
            chk($sformatf("R2 mx row %0d", r), mx, VEC[r][10]);
            chk($sformatf("R7 ch0 pins row %0d (R3 R4 R5 R6)", r), pin_out[4:0], VEC[r][9:5]);
            chk($sformatf("R7 ch1 pins row %0d (R3 R4 R5 R6)", r), pin_out[9:5], VEC[r][4:0]);
        end

        // R8 direction gating
        send(8'hF8, 1'b1);
        send(8'hF8, 1'b1);
        send(8'hF8, 1'b1);
        chk("R4 ch0 loaded 1F", pin_out[4:0], 5'h1F);
        pin_dir = 10'b00000_10100;
        #1;
        chk("R8 ch0 masked", pin_out[4:0], 5'b10100);
        chk("R8 ch1 masked off", pin_out[9:5], 5'h00);
        pin_dir = 10'h3FF;
        #1;
        chk("R8 ch0 unmasked", pin_out[4:0], 5'h1F);

        // R9 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 pins cleared by reset", pin_out, 0);
        chk("R9 strobe low in reset", octet_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        send(8'hF8, 1'b1);
        send(8'h00, 1'b1);
        chk("R9 register cleared, nothing accepted", pin_out, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule